// File: doc/BRIEF.md
# Latched Programmable Delay Line

This block delays a single-bit stream by a selectable whole number of clock cycles. Each sampled input bit is written into a circular buffer. The registered output reads the bit that was written a chosen number of cycles earlier. That number is a fixed floor, `MIN_CYCLES`, plus a `CODE_W`-bit select code. A larger design uses it to shift one timing signal against another, or to line up a bit stream with a slower path.

The select code and a separate cascade bit pass through a capture register. While `hold` is low the register follows its inputs on every clock. While `hold` is high the register keeps what it took on the last clock with `hold` low. Two override inputs, `force_min` and `force_max`, bypass the captured code. `out_off` blanks the output without disturbing the stored stream. The captured cascade bit drives a complementary output pair, so a second unit can take over the delay range beyond the first one.

For the first `MIN_CYCLES + code` cycles after reset, the output shows whatever the buffer held before reset. Buffer contents are not cleared, so the buffer can map onto block RAM.

Top module: `prog_delay_line`

## Requirements
- R1: While `rst` is high at a clock edge, the output register takes these values: `dout`=0, `casc`=0, `casc_n`=1. The captured code becomes 0 and the captured cascade bit becomes 0.
- R2: With no override active and captured code k, a bit sampled on `din` at clock edge n appears on `dout` right after edge n+`MIN_CYCLES`+k. This holds once the buffer has been filled since reset.
- R3: While `hold` is low, `code` and `casc_sel` are captured at every clock edge. A new code sets the read lag from the next edge on.
- R4: While `hold` is high at an edge, the captured code and cascade bit keep their values. Changes on `code` and `casc_sel` then have no effect on `dout`, `casc` or `casc_n`.
- R5: With `force_max` high and `force_min` low, the lag is `MIN_CYCLES` + 2^`CODE_W`. That is one step longer than the all-ones code.
- R6: With `force_min` high, the lag is `MIN_CYCLES`, whatever the states of `force_max` and the captured code.
- R7: When `out_off` is high at an edge, `dout` is 0 after that edge. The stream keeps being stored, and the delayed data returns on the first edge with `out_off` low.
- R8: `casc` takes the captured cascade bit (value before the edge) at each clock edge. `casc_n` is always its complement.
- R9: The overrides also govern the cascade pair: `force_min` high drives `casc` to 0. `force_max` high with `force_min` low drives `casc` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Bit stream to be delayed |
| code | input | CODE_W | Delay select code |
| casc_sel | input | 1 | Cascade select bit, captured with the code |
| hold | input | 1 | 0: capture register transparent, 1: locked |
| force_min | input | 1 | Force minimum lag (highest priority) |
| force_max | input | 1 | Force maximum lag |
| out_off | input | 1 | Blank the output to 0 |
| dout | output | 1 | Delayed bit stream (registered) |
| casc | output | 1 | Cascade output, true polarity |
| casc_n | output | 1 | Cascade output, inverted polarity |

## Verification
The bench builds the block with `CODE_W`=10 and `MIN_CYCLES`=3. This gives the full 1024-step code range and a floor other than the default, so an off-by-one in the floor shows up. With these values the longest lag, 1027 cycles under `force_max`, still fits in a few thousand cycles of history. The bench can therefore hold the all-ones code and the forced maximum long enough to compare across the full one-step gap between them. It can also compare every cycle of a code change, where the read point jumps backward or forward in the stored stream.

// File: rtl/pdl_pkg.sv
`timescale 1ns/1ps
package pdl_pkg;

  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_MIN  = 2'd1,
    OVR_MAX  = 2'd2
  } ovr_t;

  // minimum request outranks maximum request
  function automatic ovr_t resolve_ovr(input logic want_min, input logic want_max);
    if (want_min)      return OVR_MIN;
    else if (want_max) return OVR_MAX;
    else               return OVR_NONE;
  endfunction

endpackage

// File: rtl/pdl_sel_reg.sv
`timescale 1ns/1ps
module pdl_sel_reg #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [CODE_W-1:0] code_in,
  input  logic              casc_in,
  output logic [CODE_W-1:0] code_q,
  output logic              casc_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      casc_q <= 1'b0;
    end else if (!hold) begin
      code_q <= code_in;
      casc_q <= casc_in;
    end
  end

endmodule

// File: rtl/pdl_lag_ctrl.sv
`timescale 1ns/1ps
module pdl_lag_ctrl #(
  parameter int CODE_W     = 10,
  parameter int MIN_CYCLES = 2,
  parameter int AW         = CODE_W + 1
) (
  input  logic              [CODE_W-1:0] code_q,
  input  logic                           force_min,
  input  logic                           force_max,
  output pdl_pkg::ovr_t                  mode,
  output logic              [AW-1:0]     lag
);

  localparam logic [AW-1:0] LAG_MIN = AW'(MIN_CYCLES);
  localparam logic [AW-1:0] LAG_MAX = AW'(MIN_CYCLES + (1 << CODE_W));

  always_comb begin
    mode = pdl_pkg::resolve_ovr(force_min, force_max);
    unique case (mode)
      pdl_pkg::OVR_MIN: lag = LAG_MIN;
      pdl_pkg::OVR_MAX: lag = LAG_MAX;
      default:          lag = LAG_MIN + {{(AW-CODE_W){1'b0}}, code_q};
    endcase
  end

endmodule

// File: rtl/pdl_casc_out.sv
`timescale 1ns/1ps
module pdl_casc_out (
  input  logic          clk,
  input  logic          rst,
  input  pdl_pkg::ovr_t mode,
  input  logic          casc_q,
  output logic          casc,
  output logic          casc_n
);

  logic nxt;

  always_comb begin
    unique case (mode)
      pdl_pkg::OVR_MIN: nxt = 1'b0;
      pdl_pkg::OVR_MAX: nxt = 1'b1;
      default:          nxt = casc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      casc   <= 1'b0;
      casc_n <= 1'b1;
    end else begin
      casc   <= nxt;
      casc_n <= ~nxt;
    end
  end

endmodule

// File: rtl/pdl_ring.sv
`timescale 1ns/1ps
module pdl_ring #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic [AW-1:0] lag,
  input  logic          out_off,
  output logic          dout
);

  localparam int DEPTH = 1 << AW;

  logic          mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  assign rd_ptr = wr_ptr - lag;

  always_ff @(posedge clk) begin
    if (rst) wr_ptr <= '0;
    else     wr_ptr <= wr_ptr + 1'b1;
  end

  // plain write port, no reset on the array
  always_ff @(posedge clk) begin
    mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)          dout <= 1'b0;
    else if (out_off) dout <= 1'b0;
    else              dout <= mem[rd_ptr];
  end

endmodule

// File: rtl/prog_delay_line.sv
`timescale 1ns/1ps
module prog_delay_line #(
  parameter int CODE_W     = 10,
  parameter int MIN_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [CODE_W-1:0] code,
  input  logic              casc_sel,
  input  logic              hold,
  input  logic              force_min,
  input  logic              force_max,
  input  logic              out_off,
  output logic              dout,
  output logic              casc,
  output logic              casc_n
);

  localparam int AW = CODE_W + 1;

  generate
    if (MIN_CYCLES < 1 || MIN_CYCLES >= (1 << CODE_W)) begin : g_bad_floor
      $error("MIN_CYCLES must be in 1 .. 2**CODE_W-1");
    end
  endgenerate

  logic [CODE_W-1:0] code_q;
  logic              casc_q;
  logic [AW-1:0]     lag;
  pdl_pkg::ovr_t     mode;

  pdl_sel_reg #(.CODE_W(CODE_W)) i_sel (
    .clk(clk), .rst(rst), .hold(hold),
    .code_in(code), .casc_in(casc_sel),
    .code_q(code_q), .casc_q(casc_q)
  );

  pdl_lag_ctrl #(.CODE_W(CODE_W), .MIN_CYCLES(MIN_CYCLES), .AW(AW)) i_lag (
    .code_q(code_q), .force_min(force_min), .force_max(force_max),
    .mode(mode), .lag(lag)
  );

  pdl_ring #(.AW(AW)) i_ring (
    .clk(clk), .rst(rst), .din(din), .lag(lag),
    .out_off(out_off), .dout(dout)
  );

  pdl_casc_out i_casc (
    .clk(clk), .rst(rst), .mode(mode), .casc_q(casc_q),
    .casc(casc), .casc_n(casc_n)
  );

endmodule

// File: rtl/pdl_checker.sv
`timescale 1ns/1ps
module pdl_checker #(
  parameter int CODE_W     = 10,
  parameter int MIN_CYCLES = 2,
  parameter int AW         = CODE_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              hold,
  input logic              force_min,
  input logic              force_max,
  input logic              out_off,
  input logic              dout,
  input logic              casc,
  input logic              casc_n,
  input logic [CODE_W-1:0] code_q,
  input logic [AW-1:0]     lag
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (dout == 1'b0 && casc == 1'b0 && casc_n == 1'b1 && code_q == '0));

  assert_locked_code_R4: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(code_q));

  assert_max_lag_R5: assert property (@(posedge clk) disable iff (rst)
    (force_max && !force_min) |-> lag == AW'(MIN_CYCLES + (1 << CODE_W)));

  assert_min_wins_R6: assert property (@(posedge clk) disable iff (rst)
    force_min |-> lag == AW'(MIN_CYCLES));

  assert_blank_R7: assert property (@(posedge clk) disable iff (rst)
    out_off |=> dout == 1'b0);

  assert_casc_pair_R8: assert property (@(posedge clk) disable iff (rst)
    casc_n == ~casc);

  assert_casc_min_R9: assert property (@(posedge clk) disable iff (rst)
    force_min |=> casc == 1'b0);

  assert_casc_max_R9: assert property (@(posedge clk) disable iff (rst)
    (force_max && !force_min) |=> casc == 1'b1);

endmodule

bind prog_delay_line pdl_checker #(
  .CODE_W(CODE_W), .MIN_CYCLES(MIN_CYCLES), .AW(CODE_W + 1)
) i_pdl_checker (
  .clk(clk), .rst(rst), .hold(hold), .force_min(force_min),
  .force_max(force_max), .out_off(out_off), .dout(dout),
  .casc(casc), .casc_n(casc_n), .code_q(code_q), .lag(lag)
);

// File: tb/test_prog_delay_line.sv
`timescale 1ns/1ps
module test_prog_delay_line;

  localparam int CODE_W = 10;
  localparam int MINC   = 3;
  localparam int STEPS  = 1 << CODE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              din = 1'b0;
  logic [CODE_W-1:0] code = '0;
  logic              casc_sel = 1'b0;
  logic              hold = 1'b0;
  logic              force_min = 1'b0;
  logic              force_max = 1'b0;
  logic              out_off = 1'b0;
  logic              dout, casc, casc_n;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference state
  bit hist [$];
  int ref_code = 0;
  bit ref_casc = 0;

  always #2.5 clk = ~clk;

  prog_delay_line #(.CODE_W(CODE_W), .MIN_CYCLES(MINC)) i_prog_delay_line (
    .clk(clk), .rst(rst), .din(din), .code(code), .casc_sel(casc_sel),
    .hold(hold), .force_min(force_min), .force_max(force_max),
    .out_off(out_off), .dout(dout), .casc(casc), .casc_n(casc_n)
  );

  task automatic check(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // one clock: model the edge, then compare 1 ns later
  task automatic cyc(string req);
    int lag, m;
    bit known, exp_d, exp_c;
    @(posedge clk);
    hist.push_back(din);
    m = hist.size() - 1;
    if (force_min)      lag = MINC;
    else if (force_max) lag = MINC + STEPS;
    else                lag = MINC + ref_code;
    known = 1;
    if (out_off)           exp_d = 0;
    else if (m - lag >= 0) exp_d = hist[m - lag];
    else begin known = 0; exp_d = 0; end
    if (force_min)      exp_c = 0;
    else if (force_max) exp_c = 1;
    else                exp_c = ref_casc;
    if (!hold) begin
      ref_code = int'(code);
      ref_casc = casc_sel;
    end
    #1;
    if (known) check(req, "dout", int'(dout), int'(exp_d));
    check(req, "casc", int'(casc), int'(exp_c));
    check("R8", "casc_n", int'(casc_n), int'(!exp_c));
    din = 1'($urandom);
  endtask

  task automatic run(string req, int n);
    for (int i = 0; i < n; i++) cyc(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1", "dout", int'(dout), 0);
    check("R1", "casc", int'(casc), 0);
    check("R1", "casc_n", int'(casc_n), 1);
    rst = 0;
    din = 1'($urandom);

    // R2: plain delays with various codes
    run("R2", 100);
    code = 10'd5;    run("R2", 120);
    code = 10'd777;  run("R2", 900);
    // R3: code changes every clock while transparent
    for (int i = 0; i < 300; i++) begin
      code = CODE_W'($urandom_range(0, 40));
      casc_sel = 1'($urandom);
      cyc("R3");
    end
    // R2: all-ones code
    code = '1; run("R2", 1100);
    // R4: lock, then wiggle code and cascade select
    code = 10'd17; casc_sel = 1'b1; cyc("R4");
    hold = 1'b1;
    for (int i = 0; i < 400; i++) begin
      code = CODE_W'($urandom);
      casc_sel = 1'($urandom);
      cyc("R4");
    end
    hold = 1'b0; code = '1; casc_sel = 1'b0; run("R3", 1100);
    // R5: forced maximum, one step past all-ones
    force_max = 1'b1; run("R5", 1100);
    // R6: minimum beats maximum and code
    force_min = 1'b1; run("R6", 60);
    force_max = 1'b0; run("R6", 60);
    force_min = 1'b0; code = 10'd9; run("R2", 40);
    // R7: blanking toggles
    for (int i = 0; i < 200; i++) begin
      out_off = 1'($urandom);
      cyc("R7");
    end
    out_off = 1'b0; run("R7", 20);
    // R8 / R9: cascade bit and override effect on it
    for (int i = 0; i < 200; i++) begin
      casc_sel  = 1'($urandom);
      force_min = ($urandom_range(0, 3) == 0);
      force_max = ($urandom_range(0, 3) == 0);
      cyc((force_min || force_max) ? "R9" : "R8");
    end
    force_min = 1'b0; force_max = 1'b0; run("R8", 10);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule